// File: doc/BRIEF.md
# GPIO Per-Pin Interrupt Detector

This block turns eight external pin levels into interrupt status for a general-purpose I/O bank. Each pin has its own configuration bits: enable, mask, kind (level or edge) and active polarity. One global control bit selects whether level sources pass through a two-flop synchronizer before they are used. The block reports a raw status vector, a masked final status vector and a single combined interrupt line.

Edge-kind pins keep a detected event until software clears it. Software does this with a per-bit clear vector that pulses for exactly one clock. Level-kind pins follow their qualified input directly. The register bank that holds the configuration is outside this block, so every configuration input here is a plain vector.

Top module: `gpio_irq_detect`

## Requirements
- R1: After the asynchronous active-low reset, with all configuration inputs at zero, the raw status, final status and combined interrupt outputs are all zero.
- R2: A raw status bit is zero in every cycle in which its enable bit is zero.
- R3: The final status equals the raw status AND NOT the mask, bit by bit (mask bit 1 hides the pin).
- R4: The combined interrupt output is 1 exactly when at least one final status bit is 1.
- R5: For an enabled level-kind pin (kind bit 0) with the sync bit at 0, the raw status bit equals 1 in the same cycle that the pin equals its polarity bit. Polarity 1 means active-high and polarity 0 means active-low.
- R6: For an enabled level-kind pin with the sync bit at 1, a change of the pin reaches the raw status bit after two rising clock edges.
- R7: For an enabled edge-kind pin (kind bit 1), a rising edge (polarity 1) or a falling edge (polarity 0) on the pin sets the raw status bit on the third rising clock edge after the change. The bit then stays set while the pin returns to its earlier level.
- R8: A clear pulse on a bit resets a latched edge-kind status bit at the next rising edge. Clear bits for other pins leave those pins' latched status unchanged.
- R9: A clear pulse has no effect on a level-kind status bit.
- R10: If a qualifying edge is detected in the same cycle as a clear pulse for that pin, the status bit stays set.
- R11: Driving an enable bit to zero discards any latched edge event on that pin. Re-enabling the pin does not bring the event back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | External pin levels |
| irq_en_i | input | NPINS | Per-pin interrupt enable |
| irq_mask_i | input | NPINS | Per-pin mask, 1 hides the pin from the final status |
| irq_edge_i | input | NPINS | Per-pin kind: 1 edge, 0 level |
| irq_pol_i | input | NPINS | Per-pin polarity: 1 high/rising, 0 low/falling |
| lvl_sync_i | input | 1 | Global select: synchronize level sources |
| clr_i | input | NPINS | One-cycle per-bit clear pulse for edge events |
| raw_stat_o | output | NPINS | Status before masking |
| fin_stat_o | output | NPINS | Status after masking |
| irq_o | output | 1 | OR of all final status bits |

## Verification
On every cycle the assertions check the following: a disabled pin shows no raw status; the final status and the combined line match the raw status and the mask; an unsynchronized level pin tracks its pin against the polarity; and a latched edge survives until a clear, a disable or a change of kind. They also check that a detected edge is never lost, even when a clear arrives in the same cycle. The bench scenarios show the rest: the exact latency of the synchronized level path and of the edge path, that clears select bits and leave level pins alone, and that a disabled pin does not get its event back when it is re-enabled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NPINS_DEF = 8;

  // Level qualification: 1 where the source sits at its active level.
  function automatic logic [NPINS_DEF-1:0] lvl_active(
    input logic [NPINS_DEF-1:0] src,
    input logic [NPINS_DEF-1:0] pol
  );
    return ~(src ^ pol);
  endfunction

  // Edge qualification between the current and the previous synchronized sample.
  function automatic logic [NPINS_DEF-1:0] edge_active(
    input logic [NPINS_DEF-1:0] cur,
    input logic [NPINS_DEF-1:0] prev,
    input logic [NPINS_DEF-1:0] pol
  );
    return (cur ^ prev) & ~(cur ^ pol);
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] prev_o
);
  logic [NPINS-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      sync_o <= '0;
      prev_o <= '0;
    end else begin
      stage1 <= pin_i;
      sync_o <= stage1;
      prev_o <= sync_o;
    end
  end
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic is_edge_i,
  input  logic lvl_hit_i,
  input  logic edge_hit_i,
  input  logic clr_i,
  output logic raw_o
);
  logic held;

  // A new edge wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  held <= 1'b0;
    else if (!en_i || !is_edge_i) held <= 1'b0;
    else                         held <= (held & ~clr_i) | edge_hit_i;
  end

  always_comb begin
    raw_o = en_i & (is_edge_i ? held : lvl_hit_i);
  end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int unsigned NPINS = 8
) (
  input  logic [NPINS-1:0] raw_i,
  input  logic [NPINS-1:0] mask_i,
  output logic [NPINS-1:0] fin_o,
  output logic             any_o
);
  always_comb begin
    fin_o = raw_i & ~mask_i;
    any_o = |fin_o;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] irq_en_i,
  input  logic [NPINS-1:0] irq_mask_i,
  input  logic [NPINS-1:0] irq_edge_i,
  input  logic [NPINS-1:0] irq_pol_i,
  input  logic             lvl_sync_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] raw_stat_o,
  output logic [NPINS-1:0] fin_stat_o,
  output logic             irq_o
);
  import gpio_irq_pkg::*;

  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] pin_prev;
  logic [NPINS-1:0] lvl_src;
  logic [NPINS-1:0] lvl_hit;
  logic [NPINS-1:0] edge_evt;

  gpio_irq_sync #(.NPINS(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .sync_o (pin_sync),
    .prev_o (pin_prev)
  );

  always_comb begin
    lvl_src  = lvl_sync_i ? pin_sync : pin_i;
    lvl_hit  = lvl_active(lvl_src, irq_pol_i);
    edge_evt = edge_active(pin_sync, pin_prev, irq_pol_i);
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_cell
    gpio_irq_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (irq_en_i[g]),
      .is_edge_i  (irq_edge_i[g]),
      .lvl_hit_i  (lvl_hit[g]),
      .edge_hit_i (edge_evt[g]),
      .clr_i      (clr_i[g]),
      .raw_o      (raw_stat_o[g])
    );
  end

  gpio_irq_merge #(.NPINS(NPINS)) u_merge (
    .raw_i  (raw_stat_o),
    .mask_i (irq_mask_i),
    .fin_o  (fin_stat_o),
    .any_o  (irq_o)
  );
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_i,
  input logic [NPINS-1:0] irq_en_i,
  input logic [NPINS-1:0] irq_mask_i,
  input logic [NPINS-1:0] irq_edge_i,
  input logic [NPINS-1:0] irq_pol_i,
  input logic             lvl_sync_i,
  input logic [NPINS-1:0] clr_i,
  input logic [NPINS-1:0] edge_evt,
  input logic [NPINS-1:0] raw_stat_o,
  input logic [NPINS-1:0] fin_stat_o,
  input logic             irq_o
);
  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat_o & ~irq_en_i) == '0);

  p_final_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_stat_o == (raw_stat_o & ~irq_mask_i));

  p_irq_any_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (fin_stat_o != '0));

  for (genvar b = 0; b < NPINS; b++) begin : g_bit
    p_level_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i[b] && !irq_edge_i[b] && !lvl_sync_i)
        |-> (raw_stat_o[b] == (pin_i[b] == irq_pol_i[b])));

    p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i[b] && irq_edge_i[b] && raw_stat_o[b] && !clr_i[b])
        |=> (raw_stat_o[b] || !irq_en_i[b] || !irq_edge_i[b]));

    p_edge_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i[b] && irq_edge_i[b] && edge_evt[b])
        |=> (raw_stat_o[b] || !irq_en_i[b] || !irq_edge_i[b]));

    p_disable_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en_i[b] && !edge_evt[b])
        |=> (!raw_stat_o[b] || !irq_edge_i[b]));
  end
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_i      (pin_i),
  .irq_en_i   (irq_en_i),
  .irq_mask_i (irq_mask_i),
  .irq_edge_i (irq_edge_i),
  .irq_pol_i  (irq_pol_i),
  .lvl_sync_i (lvl_sync_i),
  .clr_i      (clr_i),
  .edge_evt   (edge_evt),
  .raw_stat_o (raw_stat_o),
  .fin_stat_o (fin_stat_o),
  .irq_o      (irq_o)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  localparam int unsigned N = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG_CYCLES = 50000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0, en = '0, mask = '0, kind = '0, pol = '0, clr = '0;
  logic         sync_sel = 1'b0;
  logic [N-1:0] raw, fin;
  logic         irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect #(.NPINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .irq_en_i(en), .irq_mask_i(mask),
    .irq_edge_i(kind), .irq_pol_i(pol), .lvl_sync_i(sync_sel), .clr_i(clr),
    .raw_stat_o(raw), .fin_stat_o(fin), .irq_o(irq)
  );

  // Level-kind, unsynchronized rows: {pin, en, mask, pol, exp_raw, exp_fin, exp_irq}
  localparam int unsigned ROWS = 5;
  localparam logic [48:0] TABLE [ROWS] = '{
    {8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b1},
    {8'h0F, 8'hFF, 8'hF0, 8'hFF, 8'h0F, 8'h0F, 1'b1},
    {8'h0F, 8'h3C, 8'h0C, 8'h00, 8'h30, 8'h30, 1'b1},
    {8'hA5, 8'hFF, 8'hFF, 8'hA5, 8'hFF, 8'h00, 1'b0},
    {8'h55, 8'h00, 8'h00, 8'h55, 8'h00, 8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    cycles(3);
    check("R1 raw", {24'h0, raw}, 32'h0);
    check("R1 fin", {24'h0, fin}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    cycles(2);
    check("R1 raw after release", {24'h0, raw}, 32'h0);

    // Table walk: R5 level, R2 enable, R3 mask, R4 combine
    for (int r = 0; r < ROWS; r++) begin
      {pin, en, mask, pol} = TABLE[r][48:17];
      #1;
      check($sformatf("R5/R2 row %0d raw", r), {24'h0, raw}, {24'h0, TABLE[r][16:9]});
      check($sformatf("R3 row %0d fin", r), {24'h0, fin}, {24'h0, TABLE[r][8:1]});
      check($sformatf("R4 row %0d irq", r), {31'h0, irq}, {31'h0, TABLE[r][0]});
      cycles(1);
    end

    // R6: synchronized level, pin 0 active-high
    en = 8'h01; mask = '0; kind = '0; pol = 8'h01; pin = '0; sync_sel = 1'b1;
    cycles(4);
    check("R6 idle", {24'h0, raw}, 32'h0);
    pin = 8'h01;
    cycles(1);
    check("R6 after one edge", {24'h0, raw}, 32'h0);
    cycles(1);
    check("R6 after two edges", {24'h0, raw}, 32'h01);
    sync_sel = 1'b0;

    // R7: rising edge on pin 0
    pin = '0; en = '0; cycles(4);
    en = 8'h01; kind = 8'h01; pol = 8'h01;
    cycles(1);
    pin = 8'h01;
    cycles(2);
    check("R7 rising before latency", {24'h0, raw}, 32'h0);
    cycles(1);
    check("R7 rising latched", {24'h0, raw}, 32'h01);
    pin = '0;
    cycles(5);
    check("R7 rising held", {24'h0, raw}, 32'h01);

    // R7: falling edge on pin 1, polarity 0
    pin = 8'h02; cycles(4);
    en = 8'h03; kind = 8'h03; pol = 8'h01;
    cycles(1);
    pin = 8'h00;
    cycles(3);
    check("R7 falling latched", {24'h0, raw}, 32'h03);

    // R8: clear only bit 0
    clr = 8'h01; cycles(1); clr = '0;
    check("R8 selective clear", {24'h0, raw}, 32'h02);
    clr = 8'h02; cycles(1); clr = '0;
    check("R8 clear bit 1", {24'h0, raw}, 32'h00);

    // R9: clear ignored by a level pin (pin 2, active-high, unsynced)
    en = 8'h04; kind = '0; pol = 8'h04; pin = 8'h04;
    #1;
    check("R9 level active", {24'h0, raw}, 32'h04);
    clr = 8'h04; cycles(1); clr = '0;
    check("R9 clear ignored", {24'h0, raw}, 32'h04);

    // R10: edge and clear in the same cycle; pin 0 already latched
    pin = '0; en = 8'h01; kind = 8'h01; pol = 8'h01;
    cycles(4);
    pin = 8'h01; cycles(3);
    check("R10 pre latch", {24'h0, raw}, 32'h01);
    pin = '0; cycles(4);
    pin = 8'h01;
    cycles(2);
    clr = 8'h01;
    cycles(1);
    clr = '0;
    check("R10 edge beats clear", {24'h0, raw}, 32'h01);

    // R11: disable drops the latched event
    en = '0; cycles(1);
    check("R11 disabled", {24'h0, raw}, 32'h00);
    en = 8'h01; cycles(3);
    check("R11 not restored", {24'h0, raw}, 32'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule